// File: doc/BRIEF.md
# Per-Sector Correction Status Scanner

After a page has moved through the flash controller with error correction on, the DMA engine leaves one 64-bit status word per correction step in a small status memory. This block reads those words one at a time and reduces them to three page results: the worst corrected-bit count of any sector, the sum of corrected bits over the page, and a failure flag for an uncorrectable sector. Each sector's zero-bit count and two user bytes are also reported as the scan passes over the sector.

A scan begins with a one-cycle `start` pulse and a step count from 0 to 63. The step count is the page size divided by the correction step size of 512 or 1024 bytes. The block issues reads on a simple word-read port, and the status memory returns data on the cycle after each read. The scan stops at the first uncorrectable sector. The last sector is not trusted until its completion flag is set, so the block keeps re-reading that word until the flag appears. A one-cycle `done` pulse marks valid results, and the results hold until the next scan.

Top module: `ecc_page_scan`

## Requirements
- R1: After reset, `done`, `busy`, `fail`, `rd_en`, `sec_vld`, `max_cnt` and `total_cnt` are all 0.
- R2: A scan with step count n ≥ 1 reads addresses 0, 1, …, n-1 in ascending order. One `rd_en` cycle is issued every two cycles, and `rd_data` is taken on the cycle after `rd_en`. Only the last address may be read more than once.
- R3: The status word fields are: bit 31 is the completion flag, bits [29:24] are the corrected count, bits [21:16] are the zero-bit count, and bits [15:0] are the user bytes, with the first byte in [7:0]. For every sector that is accepted, `sec_vld` pulses one cycle after the word is examined, carrying that sector's index, count, zero count and user bytes.
- R4: `max_cnt` is the largest corrected count among the accepted sectors.
- R5: `total_cnt` is the sum of the corrected counts of the accepted sectors.
- R6: A count of 0x3F marks an uncorrectable sector. It sets `fail`, is added to neither result, and ends the scan with `done`. No word after it is read.
- R7: When the last sector's completion flag is clear, that word is read again and `done` stays low until the flag is seen set.
- R8: `done` is a one-cycle pulse. It rises 2n clock edges after the edge that samples `start` on a complete page with no re-reads, and 2k+2 edges after it when sector k fails. Each re-read adds 2 edges. The results hold their values after `done` until the next accepted start.
- R9: An accepted start clears `fail`, `max_cnt` and `total_cnt`. `busy` is high from the edge that accepts the start until the edge that raises `done`.
- R10: A step count of 0 raises `done` at the edge that samples `start`, with all results 0 and no read.
- R11: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle scan request, accepted when idle |
| step_cnt | input | 6 | Number of sectors on the page (0 to 63) |
| rd_en | output | 1 | Status word read request |
| rd_addr | output | 6 | Sector index being read |
| rd_data | input | 64 | Status word, valid the cycle after `rd_en` |
| done | output | 1 | One-cycle pulse: page results valid |
| busy | output | 1 | Scan in progress |
| fail | output | 1 | An uncorrectable sector was found |
| max_cnt | output | 6 | Largest per-sector corrected count |
| total_cnt | output | 12 | Sum of corrected counts |
| sec_vld | output | 1 | Per-sector report valid |
| sec_idx | output | 6 | Index of the reported sector |
| sec_cnt | output | 6 | Corrected count of the reported sector |
| sec_zeros | output | 6 | Zero-bit count of the reported sector |
| sec_user | output | 16 | User bytes of the reported sector |

## Verification
Random pages mix small counts with an occasional 0x3F code and random filler in the unused bits. These pages separate the maximum from the sum, show that the scan stops at the first bad sector rather than skipping it, and show that the field positions are decoded correctly. Directed pages cover:
- a full 63-sector page at count 62, which fills the sum width;
- failure at the first sector and at the last sector;
- a last sector whose completion flag arrives late, which tests the re-read rule and the latency;
- a zero step count;
- a second `start` pulse in the middle of a scan, which must not disturb the running scan.

// File: rtl/ecc_scan_pkg.sv
package ecc_scan_pkg;

    localparam int WORD_W   = 64;
    localparam int CNT_W    = 6;
    localparam int USR_W    = 16;
    localparam int FLAG_BIT = 31;
    localparam int CNT_LSB  = 24;
    localparam int ZERO_LSB = 16;
    localparam logic [CNT_W-1:0] CNT_BAD = '1;

    typedef struct packed {
        logic             done_flag;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] zeros;
        logic [USR_W-1:0] usr;
    } sec_stat_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_EVAL
    } scan_st_t;

    function automatic logic is_uncorrectable(input logic [CNT_W-1:0] c);
        return c == CNT_BAD;
    endfunction

endpackage

// File: rtl/ecc_word_decode.sv
module ecc_word_decode
    import ecc_scan_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output sec_stat_t         stat
);

    logic unused_word_bits;
    assign unused_word_bits = ^{word[WORD_W-1:FLAG_BIT+1], word[FLAG_BIT-1],
                                word[CNT_LSB-1:ZERO_LSB+CNT_W]};

    always_comb begin
        stat.done_flag = word[FLAG_BIT];
        stat.cnt       = word[CNT_LSB +: CNT_W];
        stat.zeros     = word[ZERO_LSB +: CNT_W];
        stat.usr       = word[USR_W-1:0];
    end

endmodule

// File: rtl/ecc_scan_accum.sv
module ecc_scan_accum
    import ecc_scan_pkg::*;
#(
    parameter int TOT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             acc_en,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] max_cnt,
    output logic [TOT_W-1:0] total
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            max_cnt <= '0;
            total   <= '0;
        end else if (acc_en) begin
            if (cnt > max_cnt)
                max_cnt <= cnt;
            total <= total + {{(TOT_W-CNT_W){1'b0}}, cnt};
        end
    end

    AST_TOTAL_GROWS: assert property (@(posedge clk) disable iff (rst)
        acc_en |=> (total >= $past(total))); // R5

    AST_MAX_LE_TOTAL: assert property (@(posedge clk) disable iff (rst)
        ({{(TOT_W-CNT_W){1'b0}}, max_cnt} <= total)); // R4

endmodule

// File: rtl/ecc_scan_ctrl.sv
module ecc_scan_ctrl
    import ecc_scan_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] steps,
    input  sec_stat_t        stat,
    output logic             rd_en,
    output logic [IDX_W-1:0] idx,
    output logic             clr,
    output logic             acc_en,
    output logic             done,
    output logic             fail,
    output logic             busy
);

    scan_st_t         state;
    logic [IDX_W-1:0] last;
    logic             is_last;
    logic             waiting;
    logic             bad;

    assign is_last = (idx == last);
    assign waiting = (state == ST_EVAL) && is_last && !stat.done_flag;
    assign bad     = is_uncorrectable(stat.cnt);

    assign rd_en  = (state == ST_ISSUE);
    assign busy   = (state != ST_IDLE);
    assign clr    = (state == ST_IDLE) && start;
    assign acc_en = (state == ST_EVAL) && !waiting && !bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
            last  <= '0;
            done  <= 1'b0;
            fail  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        fail <= 1'b0;
                        idx  <= '0;
                        last <= steps - 1'b1;
                        if (steps == '0)
                            done <= 1'b1;
                        else
                            state <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state <= ST_EVAL;
                ST_EVAL: begin
                    if (waiting) begin
                        state <= ST_ISSUE;
                    end else if (bad) begin
                        fail  <= 1'b1;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else if (is_last) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= ST_ISSUE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (idx <= last)); // R2

    AST_FAIL_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(fail) |-> done); // R6

endmodule

// File: rtl/ecc_page_scan.sv
module ecc_page_scan
    import ecc_scan_pkg::*;
#(
    parameter int MAX_STEPS = 63
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             start,
    input  logic [$clog2(MAX_STEPS+1)-1:0]   step_cnt,
    output logic                             rd_en,
    output logic [$clog2(MAX_STEPS+1)-1:0]   rd_addr,
    input  logic [63:0]                      rd_data,
    output logic                             done,
    output logic                             busy,
    output logic                             fail,
    output logic [5:0]                       max_cnt,
    output logic [$clog2(MAX_STEPS*62+1)-1:0] total_cnt,
    output logic                             sec_vld,
    output logic [$clog2(MAX_STEPS+1)-1:0]   sec_idx,
    output logic [5:0]                       sec_cnt,
    output logic [5:0]                       sec_zeros,
    output logic [15:0]                      sec_user
);

    localparam int IDX_W = $clog2(MAX_STEPS + 1);
    localparam int TOT_W = $clog2(MAX_STEPS * (int'(CNT_BAD) - 1) + 1);

    sec_stat_t        stat;
    logic [IDX_W-1:0] idx;
    logic             clr;
    logic             acc_en;

    ecc_word_decode u_dec (
        .word (rd_data),
        .stat (stat)
    );

    ecc_scan_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .steps  (step_cnt),
        .stat   (stat),
        .rd_en  (rd_en),
        .idx    (idx),
        .clr    (clr),
        .acc_en (acc_en),
        .done   (done),
        .fail   (fail),
        .busy   (busy)
    );

    ecc_scan_accum #(.TOT_W(TOT_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .acc_en  (acc_en),
        .cnt     (stat.cnt),
        .max_cnt (max_cnt),
        .total   (total_cnt)
    );

    assign rd_addr = idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_vld   <= 1'b0;
            sec_idx   <= '0;
            sec_cnt   <= '0;
            sec_zeros <= '0;
            sec_user  <= '0;
        end else begin
            sec_vld <= acc_en;
            if (acc_en) begin
                sec_idx   <= idx;
                sec_cnt   <= stat.cnt;
                sec_zeros <= stat.zeros;
                sec_user  <= stat.usr;
            end
        end
    end

    AST_NO_READ_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !rd_en); // R6

    AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done); // R9

    AST_REPORT_GOOD: assert property (@(posedge clk) disable iff (rst)
        sec_vld |-> (sec_cnt != CNT_BAD)); // R3

endmodule

// File: tb/tb_ecc_page_scan.sv
`timescale 1ns/1ps
module tb_ecc_page_scan;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  step_cnt = '0;
    logic        rd_en;
    logic [5:0]  rd_addr;
    logic [63:0] rd_data = '0;
    logic        done, busy, fail, sec_vld;
    logic [5:0]  max_cnt, sec_idx, sec_cnt, sec_zeros;
    logic [11:0] total_cnt;
    logic [15:0] sec_user;

    int checks = 0;
    int errors = 0;
    logic [63:0] mem [64];

    int scan_n = 0, prev_addr = -1, rd_count = 0, rd_bad = 0, usr_count = 0, usr_bad = 0;

    always #10 clk = ~clk;

    ecc_page_scan dut (
        .clk(clk), .rst(rst), .start(start), .step_cnt(step_cnt),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done), .busy(busy), .fail(fail), .max_cnt(max_cnt),
        .total_cnt(total_cnt), .sec_vld(sec_vld), .sec_idx(sec_idx),
        .sec_cnt(sec_cnt), .sec_zeros(sec_zeros), .sec_user(sec_user)
    );

    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    always @(negedge clk) begin
        if (!rst && rd_en) begin
            int want;
            want = (prev_addr < 0) ? 0 : ((prev_addr == scan_n - 1) ? prev_addr : prev_addr + 1);
            if (int'(rd_addr) != want) rd_bad++;
            prev_addr = int'(rd_addr);
            rd_count++;
        end
        if (!rst && sec_vld) begin
            logic [63:0] w;
            w = mem[sec_idx];
            if (sec_cnt != w[29:24] || sec_zeros != w[21:16] || sec_user != w[15:0]) usr_bad++;
            usr_count++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_word(input int c, input bit flag);
        logic [63:0] w;
        w = {$urandom, $urandom};
        w[31] = flag;
        w[29:24] = 6'(c);
        return w;
    endfunction

    task automatic run_scan(input int n, input int flag_at, input bit poke, input string tag);
        bit   e_fail = 0;
        int   e_max = 0, e_tot = 0, e_stop = n, e_good = 0, e_cyc, j = 0, cyc = 0;
        for (int i = 0; i < n; i++) begin
            int c;
            c = int'(mem[i][29:24]);
            if (c == 63) begin e_fail = 1; e_stop = i; break; end
            e_good++;
            e_tot += c;
            if (c > e_max) e_max = c;
        end
        if (e_fail) e_cyc = 2 * e_stop + 3;
        else if (n == 0) e_cyc = 1;
        else begin
            if (flag_at > 0) while (2 * n - 1 + 2 * j < flag_at) j++;
            e_cyc = 2 * n + 1 + 2 * j;
        end
        scan_n = n; prev_addr = -1; rd_count = 0; rd_bad = 0; usr_count = 0; usr_bad = 0;
        @(negedge clk);
        step_cnt = 6'(n);
        start = 1'b1;
        while (cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (done) break;
            if (cyc == 1) start = 1'b0;
            if (poke && cyc == 3) begin start = 1'b1; step_cnt = '0; end
            if (poke && cyc == 4) start = 1'b0;
            if (flag_at > 0 && cyc == flag_at) mem[n - 1][31] = 1'b1;
        end
        start = 1'b0;
        chk(done == 1'b1, "R8", {tag, " done seen (watchdog)"}, int'(done), 1);
        chk(cyc == e_cyc, (flag_at > 0) ? "R7" : "R8", {tag, " done latency"}, cyc, e_cyc);
        chk(fail == e_fail, "R6", {tag, " fail"}, int'(fail), int'(e_fail));
        chk(int'(max_cnt) == e_max, "R4", {tag, " max"}, int'(max_cnt), e_max);
        chk(int'(total_cnt) == e_tot, "R5", {tag, " total"}, int'(total_cnt), e_tot);
        chk(rd_bad == 0 && (flag_at > 0 || rd_count == (e_fail ? e_stop + 1 : n)),
            "R2", {tag, " read order/count"}, rd_count, e_fail ? e_stop + 1 : n);
        @(negedge clk);
        chk(usr_bad == 0 && usr_count == e_good, "R3", {tag, " sector reports"}, usr_count, e_good);
        chk(!done && max_cnt == 6'(e_max) && total_cnt == 12'(e_tot) && fail == e_fail,
            "R8", {tag, " pulse ends, results hold"}, int'(total_cnt), e_tot);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        process::self().srandom(32'h5eed_0042);
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !busy && !fail && !rd_en && !sec_vld && max_cnt == 0 && total_cnt == 0,
            "R1", "reset state", int'(busy), 0);

        // R4 R5 R3: directed page of mixed counts, distinct max vs sum
        for (int i = 0; i < 4; i++) mem[i] = mk_word(i * 2 + 1, i == 3);
        run_scan(4, 0, 0, "mixed");

        // R5: full-size page at count 62 fills the sum width
        for (int i = 0; i < 63; i++) mem[i] = mk_word(62, 1);
        run_scan(63, 0, 0, "full62");

        // R6: failure at the first and at the last sector
        for (int i = 0; i < 8; i++) mem[i] = mk_word(3, 1);
        mem[0][29:24] = 6'h3F;
        run_scan(8, 0, 0, "fail_first");
        mem[0][29:24] = 6'd5;
        mem[7][29:24] = 6'h3F;
        run_scan(8, 0, 0, "fail_last");

        // R7: late completion flag on the last sector
        for (int i = 0; i < 5; i++) mem[i] = mk_word(i, 1);
        mem[4][31] = 1'b0;
        run_scan(5, 30, 0, "late_flag");

        // R9 R10: zero steps clears earlier results and ends at once
        run_scan(0, 0, 0, "zero_steps");
        chk(max_cnt == 0 && total_cnt == 0 && !fail, "R9", "results cleared by start", int'(total_cnt), 0);

        // R11: second start while busy ignored
        for (int i = 0; i < 6; i++) mem[i] = mk_word(4, 1);
        run_scan(6, 0, 1, "start_busy_R11");

        // random pages
        for (int t = 0; t < 40; t++) begin
            int n;
            n = $urandom_range(1, 63);
            for (int i = 0; i < 64; i++) begin
                int c;
                c = ($urandom_range(0, 29) == 0) ? 63 : $urandom_range(0, 12);
                mem[i] = mk_word(c, (i == n - 1) ? 1'b1 : 1'($urandom));
            end
            run_scan(n, 0, 0, "random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule